// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block manages 32 general-purpose pins from a simple bus with no wait states. A transfer is complete in the cycle where `bus_en` is high. Each pin can drive its pad as an output or can be read as an input. An input pin can have a pull resistor. While a pin is an input, its output-data bit decides whether that resistor pulls up or down. A pin can also be given to an alternate function, and then the bank stops driving it.

Pad inputs pass through a two-flop synchroniser. The synchronised value is then compared with its own value one clock earlier. A rising or falling transition that is enabled by its mask latches a sticky status bit. The bank drives a single registered interrupt line, which is high while any status bit is set. Software changes output data and direction through separate set and clear registers, so no read-modify-write is needed for those. Interrupt status clears when software writes ones to the clear register.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous reset all pins are inputs, all pulls are on, output data is 0, no alternate function is selected, both edge masks and all status bits are 0, and `irq` and `bus_rdata` are 0.
- R2: Writing to 0x04 sets the output-data bits where the written value has a 1, and writing to 0x08 clears them. Zero bits are unchanged. `pad_out` shows output data, and 0x1C reads it back.
- R3: Writing ones to 0x0C makes those pins outputs, and writing ones to 0x10 makes them inputs. 0x18 reads direction back (1 = output). `pad_oe` is high for output pins that are not in alternate mode.
- R4: A read of 0x00 returns the pad levels synchronised through two flops. A pad change before edge k is visible in a read issued at edge k+2. Read data appears on `bus_rdata` one cycle after the read and holds until the next read.
- R5: Register 0x14 is read/write, and a 1 disables a pin's pull. `pad_pull_en` is high for input pins whose pull is enabled and that are not in alternate mode. `pad_pull_up` equals the output-data bit (1 = pull-up, 0 = pull-down).
- R6: Register 0x20 is read/write and selects the alternate function per pin (1 = alternate). It drives `pad_alt`. An alternate pin has `pad_oe` and `pad_pull_en` low.
- R7: Registers 0x24 (rising) and 0x28 (falling) are read/write edge masks. An edge of the synchronised input latches its status bit only when its mask bit is 1. Setting both mask bits catches both edges. Status is set two edges after the pad change.
- R8: Status reads at 0x2C and stays set until a 1 is written to its bit at 0x30. Writing all ones clears every bit.
- R9: If an edge event and a clear of the same bit occur in the same cycle, the bit ends up set.
- R10: `irq` is registered and is high exactly while at least one status bit is set.
- R11: Writes to 0x00, 0x18, 0x1C, 0x2C and to unmapped offsets change no state. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Transfer strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin |
| pad_pull_en | output | 32 | Pull resistor enable per pin |
| pad_pull_up | output | 32 | Pull direction, 1 = up |
| pad_alt | output | 32 | Alternate function select per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
A corrupted output-data, direction, pull or alternate register shows on the pad-control outputs on the clock edge that follows the faulty update, and again in the next readback. A wrong synchroniser depth or a wrong edge comparison moves the status bit and `irq` by a cycle, so they are compared on every clock against a model that keeps a history of pad samples. A lost or extra status bit appears on `irq` in the same cycle and on the next status read. The same-cycle collision between an edge and a clear is forced deliberately, to expose a design where the clear wins.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_LEVEL    = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_DOUT_SET = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_DOUT_CLR = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_DIR_SET  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_DIR_CLR  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_PULL_OFF = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_DIR_RD   = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_DOUT_RD  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_ALT      = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_RISE_EN  = 6'h24;
  localparam logic [ADDR_W-1:0] OFF_FALL_EN  = 6'h28;
  localparam logic [ADDR_W-1:0] OFF_STAT     = 6'h2C;
  localparam logic [ADDR_W-1:0] OFF_STAT_CLR = 6'h30;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_q,
  output logic [W-1:0] prev_q
);
  logic [W-1:0] meta_q;

  // two-flop synchroniser followed by a one-cycle history flop
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  // R4: history flop follows the synchronised value by exactly one cycle
  assert_history_lag_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> prev_q == $past(sync_q));
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_q,
  input  logic [W-1:0] prev_q,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] stat_q,
  output logic         irq
);
  logic [W-1:0] rise_evt, fall_evt, evt, stat_nx, clr_bits;

  always_comb begin
    rise_evt = sync_q & ~prev_q & rise_en;
    fall_evt = ~sync_q & prev_q & fall_en;
    evt      = rise_evt | fall_evt;
    clr_bits = clr_we ? clr_mask : '0;
    // a fresh event beats a clear of the same bit
    stat_nx  = (stat_q & ~clr_bits) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_nx;
      irq    <= |stat_nx;
    end
  end

  assert_irq_or_R10: assert property (@(posedge clk) disable iff (rst)
    irq == (stat_q != '0));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> (stat_q & $past(stat_q)) == $past(stat_q));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_q & $past(evt)) == $past(evt));

  assert_masked_R7: assert property (@(posedge clk) disable iff (rst)
    (rise_en == '0 && fall_en == '0 && clr_we == 1'b0) |=> stat_q == $past(stat_q));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      level,
  input  logic [W-1:0]      stat,
  output logic [W-1:0]      dout_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      poff_q,
  output logic [W-1:0]      alt_q,
  output logic [W-1:0]      rise_q,
  output logic [W-1:0]      fall_q,
  output logic              clr_we,
  output logic [W-1:0]      clr_mask
);
  logic          we, re;
  logic [W-1:0]  rd_mux;

  assign we       = bus_en & bus_wr;
  assign re       = bus_en & ~bus_wr;
  assign clr_we   = we && (bus_addr == OFF_STAT_CLR);
  assign clr_mask = bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dir_q  <= '0;
      poff_q <= '0;
      alt_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (we) begin
      case (bus_addr)
        OFF_DOUT_SET: dout_q <= dout_q | bus_wdata;
        OFF_DOUT_CLR: dout_q <= dout_q & ~bus_wdata;
        OFF_DIR_SET:  dir_q  <= dir_q | bus_wdata;
        OFF_DIR_CLR:  dir_q  <= dir_q & ~bus_wdata;
        OFF_PULL_OFF: poff_q <= bus_wdata;
        OFF_ALT:      alt_q  <= bus_wdata;
        OFF_RISE_EN:  rise_q <= bus_wdata;
        OFF_FALL_EN:  fall_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_LEVEL:    rd_mux = level;
      OFF_PULL_OFF: rd_mux = poff_q;
      OFF_DIR_RD:   rd_mux = dir_q;
      OFF_DOUT_RD:  rd_mux = dout_q;
      OFF_ALT:      rd_mux = alt_q;
      OFF_RISE_EN:  rd_mux = rise_q;
      OFF_FALL_EN:  rd_mux = fall_q;
      OFF_STAT:     rd_mux = stat;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (re) bus_rdata <= rd_mux;
  end

  assert_dout_set_R2: assert property (@(posedge clk) disable iff (rst)
    (we && bus_addr == OFF_DOUT_SET) |=> (dout_q & $past(bus_wdata)) == $past(bus_wdata));

  assert_dout_clr_R2: assert property (@(posedge clk) disable iff (rst)
    (we && bus_addr == OFF_DOUT_CLR) |=> (dout_q & $past(bus_wdata)) == '0);

  assert_dir_clr_R3: assert property (@(posedge clk) disable iff (rst)
    (we && bus_addr == OFF_DIR_CLR) |=> (dir_q & $past(bus_wdata)) == '0);

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(bus_rdata));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_pull_en,
  output logic [W-1:0]      pad_pull_up,
  output logic [W-1:0]      pad_alt,
  output logic              irq
);
  logic [W-1:0] sync_q, prev_q, stat_q;
  logic [W-1:0] dout_q, dir_q, poff_q, alt_q, rise_q, fall_q, clr_mask;
  logic         clr_we;

  gpio_bank_sync #(.W(W)) u_sync (
    .clk(clk), .rst(rst), .raw_in(pad_in), .sync_q(sync_q), .prev_q(prev_q)
  );

  gpio_bank_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .level(sync_q), .stat(stat_q),
    .dout_q(dout_q), .dir_q(dir_q), .poff_q(poff_q), .alt_q(alt_q),
    .rise_q(rise_q), .fall_q(fall_q), .clr_we(clr_we), .clr_mask(clr_mask)
  );

  gpio_bank_irq #(.W(W)) u_irq (
    .clk(clk), .rst(rst), .sync_q(sync_q), .prev_q(prev_q),
    .rise_en(rise_q), .fall_en(fall_q), .clr_we(clr_we), .clr_mask(clr_mask),
    .stat_q(stat_q), .irq(irq)
  );

  // pad controls decode straight from flops, so they are glitch-free
  assign pad_out     = dout_q;
  assign pad_alt     = alt_q;
  assign pad_oe      = dir_q & ~alt_q;
  assign pad_pull_en = ~dir_q & ~poff_q & ~alt_q;
  assign pad_pull_up = dout_q;

  assert_pull_vs_drive_R5: assert property (@(posedge clk) disable iff (rst)
    (pad_pull_en & pad_oe) == '0);

  assert_alt_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe | pad_pull_en) & pad_alt) == '0);
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int W = 32;
  localparam logic [5:0] A_LVL = 6'h00, A_DS = 6'h04, A_DC = 6'h08, A_RS = 6'h0C,
                         A_RC = 6'h10, A_PO = 6'h14, A_DIR = 6'h18, A_DOUT = 6'h1C,
                         A_ALT = 6'h20, A_RE = 6'h24, A_FE = 6'h28, A_ST = 6'h2C,
                         A_CL = 6'h30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, pad_in = '0;
  logic [W-1:0] bus_rdata, pad_out, pad_oe, pad_pull_en, pad_pull_up, pad_alt;
  logic irq;

  always #10 clk = ~clk;

  gpio_bank #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
    .pad_alt(pad_alt), .irq(irq)
  );

  // behavioural model
  logic [W-1:0] m_dout = '0, m_dir = '0, m_poff = '0, m_alt = '0, m_rise = '0, m_fall = '0;
  logic [W-1:0] m_stat = '0, m_rdata = '0;
  logic         m_irq = 1'b0;
  logic [W-1:0] hist[$] = '{32'h0, 32'h0, 32'h0}; // oldest first, one pad sample per edge
  int vectors = 0, errors = 0;
  string phase = "R1";
  bit done = 1'b0;

  always @(posedge clk) begin
    logic [W-1:0] lvl, old_lvl, nxt;
    if (rst) begin
      m_dout = '0; m_dir = '0; m_poff = '0; m_alt = '0; m_rise = '0; m_fall = '0;
      m_stat = '0; m_rdata = '0; m_irq = 1'b0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      lvl = hist[1];
      old_lvl = hist[0];
      nxt = m_stat;
      if (bus_en && bus_wr && bus_addr == A_CL) nxt = nxt & ~bus_wdata;
      for (int i = 0; i < W; i++) begin
        if (lvl[i] && !old_lvl[i] && m_rise[i]) nxt[i] = 1'b1;
        if (!lvl[i] && old_lvl[i] && m_fall[i]) nxt[i] = 1'b1;
      end
      if (bus_en && !bus_wr) begin
        case (bus_addr)
          A_LVL: m_rdata = lvl;   A_PO: m_rdata = m_poff;  A_DIR: m_rdata = m_dir;
          A_DOUT: m_rdata = m_dout; A_ALT: m_rdata = m_alt; A_RE: m_rdata = m_rise;
          A_FE: m_rdata = m_fall; A_ST: m_rdata = m_stat;  default: m_rdata = '0;
        endcase
      end
      if (bus_en && bus_wr) begin
        case (bus_addr)
          A_DS: m_dout = m_dout | bus_wdata;  A_DC: m_dout = m_dout & ~bus_wdata;
          A_RS: m_dir = m_dir | bus_wdata;    A_RC: m_dir = m_dir & ~bus_wdata;
          A_PO: m_poff = bus_wdata;  A_ALT: m_alt = bus_wdata;
          A_RE: m_rise = bus_wdata;  A_FE: m_fall = bus_wdata;
          default: ;
        endcase
      end
      m_stat = nxt;
      m_irq = (nxt != '0);
      hist.push_back(pad_in);
      void'(hist.pop_front());
    end
  end

  task automatic cmp(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) t=%0t actual=%h expected=%h", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      cmp("R2 pad_out", pad_out, m_dout);
      cmp("R3 pad_oe", pad_oe, m_dir & ~m_alt);
      cmp("R5 pad_pull_en", pad_pull_en, ~m_dir & ~m_poff & ~m_alt);
      cmp("R5 pad_pull_up", pad_pull_up, m_dout);
      cmp("R6 pad_alt", pad_alt, m_alt);
      cmp("R10 irq", {31'b0, irq}, {31'b0, m_irq});
      cmp("R4 bus_rdata", bus_rdata, m_rdata);
    end
  end

  // tasks are entered at a negative edge and return at one
  task automatic wr(logic [5:0] a, logic [W-1:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    phase = "R1"; idle(2);
    for (int a = 0; a <= 'h30; a += 4) rd(6'(a));
    phase = "R2"; wr(A_DS, 32'hF0F0_00FF); wr(A_DC, 32'h0000_000F); wr(A_DS, 32'h0); rd(A_DOUT);
    phase = "R3"; wr(A_RS, 32'h0000_FFFF); wr(A_RC, 32'h0000_00F0); rd(A_DIR);
    phase = "R5"; wr(A_PO, 32'h0F00_0F00); rd(A_PO); wr(A_RC, 32'h0000_0F0F);
    phase = "R6"; wr(A_ALT, 32'h8000_0101); rd(A_ALT);
    phase = "R4"; pad_in = 32'hA5A5_5A5A; rd(A_LVL); rd(A_LVL); rd(A_LVL);
    pad_in = 32'h0000_FFFF; idle(1); rd(A_LVL);
    phase = "R7"; wr(A_RE, 32'h0000_000F); wr(A_FE, 32'h0000_00F0);
    pad_in = 32'h0000_0000; idle(4); rd(A_ST);
    pad_in = 32'h0000_00FF; idle(4); rd(A_ST);
    wr(A_RE, 32'h0001_0000); wr(A_FE, 32'h0001_0000);
    pad_in = 32'h0001_00FF; idle(4); rd(A_ST);
    pad_in = 32'h0000_00FF; idle(4); rd(A_ST);
    phase = "R8"; wr(A_CL, 32'h0000_0003); rd(A_ST); idle(3);
    wr(A_CL, 32'hFFFF_FFFF); rd(A_ST); idle(3);
    phase = "R9"; pad_in = 32'h0001_00FF; idle(2); wr(A_CL, 32'hFFFF_FFFF); rd(A_ST);
    pad_in = 32'h0000_00FF; idle(1); wr(A_CL, 32'h0001_0000); rd(A_ST);
    idle(1); wr(A_CL, 32'hFFFF_FFFF); rd(A_ST);
    phase = "R11"; wr(A_LVL, 32'hFFFF_FFFF); wr(A_DIR, 32'hFFFF_FFFF); wr(A_DOUT, 32'h0);
    wr(A_ST, 32'hFFFF_FFFF); wr(6'h3C, 32'hFFFF_FFFF); wr(6'h34, 32'h1234_5678);
    rd(A_DIR); rd(A_DOUT); rd(A_ST); rd(6'h3C);
    phase = "R10"; wr(A_RE, 32'hFFFF_FFFF); pad_in = 32'hFFFF_FFFF; idle(4); rd(A_ST);
    wr(A_CL, 32'hFFFF_FFFF); idle(2);
    phase = "R1"; rst = 1'b1; idle(2); rst = 1'b0; idle(1); rd(A_RE); rd(A_DOUT);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    finish_run();
  end
endmodule